// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block works next to a simple instruction-cycle controller. It collects interrupt requests from several classes and holds them as pending. It takes one only when the controller reports that an instruction has finished. The controller already increments the counter before the end of each instruction, so the counter value offered at that moment is the return address.

When it takes a request, the sequencer does four things. It emits a save strobe carrying that counter value. It switches the mode bit to supervisor. It issues a one-cycle read of a vector table at fixed low addresses, with one entry per class. When the table answers, it tells the controller to load the new counter. From the moment of entry until a return strobe arrives, no further requests are taken, but new arrivals stay pending. The return strobe reloads the saved counter and restores the mode bit that was in force before entry.

Mode bit encoding: 1 is supervisor, 0 is user. The vector address of class k is `VEC_BASE + k * VEC_STRIDE`. With the default parameters (base 16, stride 2) this gives addresses 16, 18, 20 and so on.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted and right after it, `save_valid`, `vec_req`, `pc_load` and `mode_we` are all low and no request is pending.
- R2: A pending request is taken only on a cycle where `instr_done` is high. A request that arrives without `instr_done` only becomes pending.
- R3: When several classes are pending (held or arriving in the taking cycle), the lowest-numbered class is taken. The others stay pending.
- R4: The cycle after a take, `save_valid` is high for exactly one cycle, and `save_pc` equals `pc_in` from the taking cycle.
- R5: In that same cycle, `vec_req` is high for exactly one cycle with `vec_addr = VEC_BASE + class * VEC_STRIDE`.
- R6: When `vec_valid` is high while the read is outstanding, `pc_load` is high on the next cycle with `pc_load_val` equal to that `vec_data`.
- R7: The cycle after a take, `mode_we` is high with `mode_val = 1` (supervisor).
- R8: From a take until the return is accepted, no further entry happens, whatever `instr_done` and `irq_req` do. Requests arriving in that window stay pending.
- R9: A `rti` pulse after the vector load gives, on the next cycle, `pc_load` with the saved counter, and `mode_we` with the `mode_in` value captured at the take.
- R10: A `rti` pulse while no handler is active has no effect on any output.
- R11: A request held pending through the masked window is taken at the first `instr_done` after the return cycle.
- R12: `vec_valid` in the cycle that carries `vec_req`, or while idle or in a handler, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_CLS | One pulse per class marks a new request |
| instr_done | input | 1 | End-of-instruction strobe |
| pc_in | input | AW | Incremented instruction counter |
| mode_in | input | 1 | Current mode bit (1 = supervisor) |
| rti | input | 1 | Return-from-interrupt strobe |
| vec_valid | input | 1 | Vector read data valid |
| vec_data | input | AW | Vector read data |
| save_valid | output | 1 | Counter save strobe |
| save_pc | output | AW | Counter value to store |
| vec_req | output | 1 | Vector table read request |
| vec_addr | output | AW | Vector table address |
| pc_load | output | 1 | Counter load strobe |
| pc_load_val | output | AW | New counter value |
| mode_we | output | 1 | Mode bit write strobe |
| mode_val | output | 1 | Mode bit value to write |

## Verification
The directed part first pulses a high class with no boundary, to separate arrival from taking. It then raises a lower class together with the boundary, which shows that arrivals in the taking cycle join the priority pick. Boundaries and new arrivals inside a handler show that masking holds while requests are kept. The return is followed by an immediate boundary, which shows that a kept request is taken first and that the lowest class still wins. Early read data and stray return strobes are driven to tell ignored inputs from accepted ones. A long random phase then mixes all inputs against a behavioural model on every clock, so that rare overlaps of arrival, boundary and return are covered.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HDL  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_pend_pick.sv
module irq_pend_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0] pend_q, pend_d, merged, grant;
  logic         blk;

  assign merged = pend_q | req_in;
  assign any    = |merged;

  always_comb begin
    blk     = 1'b0;
    grant   = '0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (merged[i] && !blk) begin
        grant[i] = 1'b1;
        win_idx  = IW'(i);
      end
      blk = blk | merged[i];
    end
  end

  always_comb begin
    pend_d = merged;
    if (take) pend_d = merged & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3

  for (genvar k = 0; k < N; k++) begin : g_hold
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[k] && !(take && grant[k])) |=> pend_q[k]); // R8
    AST_ARRIVAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in[k] && !take) |=> pend_q[k]); // R2
  end
endmodule

// File: rtl/irq_ctx_save.sv
module irq_ctx_save #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] pc_in,
  input  logic          mode_in,
  output logic [AW-1:0] pc_q,
  output logic          mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mode_q <= 1'b0;
    end else if (cap) begin
      pc_q   <= pc_in;
      mode_q <= mode_in;
    end
  end

  AST_CTX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(pc_q) && $stable(mode_q))); // R9
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          N_CLS      = 8,
  parameter int          AW         = 16,
  parameter int unsigned VEC_BASE   = 16,
  parameter int unsigned VEC_STRIDE = 2,
  localparam int IW = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLS-1:0] irq_req,
  input  logic             instr_done,
  input  logic [AW-1:0]    pc_in,
  input  logic             mode_in,
  input  logic             rti,
  input  logic             vec_valid,
  input  logic [AW-1:0]    vec_data,
  output logic             save_valid,
  output logic [AW-1:0]    save_pc,
  output logic             vec_req,
  output logic [AW-1:0]    vec_addr,
  output logic             pc_load,
  output logic [AW-1:0]    pc_load_val,
  output logic             mode_we,
  output logic             mode_val
);
  seq_state_t    st_q, st_d;
  logic          pend_any, take, fetch_done, ret_go;
  logic [IW-1:0] win_idx;
  logic [AW-1:0] ctx_pc, addr_d, load_val_d;
  logic          ctx_mode, mode_val_d;
  logic          save_q, vreq_q, load_q, mwe_q;

  irq_pend_pick #(.N(N_CLS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_in(irq_req), .take(take),
    .any(pend_any), .win_idx(win_idx)
  );

  irq_ctx_save #(.AW(AW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .cap(take), .pc_in(pc_in), .mode_in(mode_in),
    .pc_q(ctx_pc), .mode_q(ctx_mode)
  );

  always_comb begin
    st_d       = st_q;
    take       = 1'b0;
    fetch_done = 1'b0;
    ret_go     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (instr_done && pend_any) begin
        take = 1'b1;
        st_d = ST_REQ;
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (vec_valid) begin
        fetch_done = 1'b1;
        st_d       = ST_HDL;
      end
      ST_HDL:  if (rti) begin
        ret_go = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_d     = AW'(VEC_BASE) + AW'(win_idx) * AW'(VEC_STRIDE);
    load_val_d = fetch_done ? vec_data : ctx_pc;
    mode_val_d = take ? 1'b1 : ctx_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      save_q <= 1'b0;
      vreq_q <= 1'b0;
      load_q <= 1'b0;
      mwe_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      save_q <= take;
      vreq_q <= take;
      load_q <= fetch_done | ret_go;
      mwe_q  <= take | ret_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_addr    <= '0;
      pc_load_val <= '0;
      mode_val    <= 1'b0;
    end else begin
      if (take)                vec_addr    <= addr_d;
      if (fetch_done | ret_go) pc_load_val <= load_val_d;
      if (take | ret_go)       mode_val    <= mode_val_d;
    end
  end

  assign save_valid = save_q;
  assign save_pc    = ctx_pc;
  assign vec_req    = vreq_q;
  assign pc_load    = load_q;
  assign mode_we    = mwe_q;

  AST_ENTRY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> $past(instr_done)); // R2
  AST_VREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req); // R5
  AST_ENTRY_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> (mode_we && mode_val)); // R7
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($past(vec_valid) || $past(rti))); // R6
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |=> !save_valid); // R8
  AST_RTI_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rti) |=> !pc_load); // R10
  AST_EARLY_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !pc_load); // R12
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int NC = 8;
  localparam int AWB = 16;
  localparam int BASE = 16;
  localparam int STRIDE = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]  irq_req;
  logic           instr_done, mode_in, rti, vec_valid;
  logic [AWB-1:0] pc_in, vec_data;
  logic           save_valid, vec_req, pc_load, mode_we, mode_val;
  logic [AWB-1:0] save_pc, vec_addr, pc_load_val;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_entry_seq #(.N_CLS(NC), .AW(AWB), .VEC_BASE(BASE), .VEC_STRIDE(STRIDE)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
    .pc_in(pc_in), .mode_in(mode_in), .rti(rti), .vec_valid(vec_valid),
    .vec_data(vec_data), .save_valid(save_valid), .save_pc(save_pc),
    .vec_req(vec_req), .vec_addr(vec_addr), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .mode_we(mode_we), .mode_val(mode_val)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int             m_st;
  logic [NC-1:0]  m_pend, m_merged;
  logic [AWB-1:0] m_spc;
  logic           m_smode;
  logic           e_save, e_vreq, e_load, e_mwe, e_mval;
  logic [AWB-1:0] e_spc, e_vaddr, e_lval;
  int             w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pend = '0;
      e_save = 0; e_vreq = 0; e_load = 0; e_mwe = 0;
    end else begin
      m_merged = m_pend | irq_req;
      e_save = 0; e_vreq = 0; e_load = 0; e_mwe = 0;
      if (m_st == 0 && instr_done && m_merged != '0) begin
        w = -1;
        for (int i = NC - 1; i >= 0; i--) if (m_merged[i]) w = i;
        e_save = 1; e_spc = pc_in;
        e_vreq = 1; e_vaddr = AWB'(BASE + STRIDE * w);
        e_mwe = 1; e_mval = 1;
        m_spc = pc_in; m_smode = mode_in;
        m_merged[w] = 1'b0;
        m_st = 1;
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (m_st == 2 && vec_valid) begin
        e_load = 1; e_lval = vec_data; m_st = 3;
      end else if (m_st == 3 && rti) begin
        e_load = 1; e_lval = m_spc; e_mwe = 1; e_mval = m_smode; m_st = 0;
      end
      m_pend = m_merged;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(save_valid == e_save, "R4 save strobe", save_valid, e_save);
      if (e_save) chk(save_pc == e_spc, "R4 saved counter", save_pc, e_spc);
      chk(vec_req == e_vreq, "R5 vector request", vec_req, e_vreq);
      if (e_vreq) chk(vec_addr == e_vaddr, "R3 vector address", vec_addr, e_vaddr);
      chk(pc_load == e_load, "R6 counter load strobe", pc_load, e_load);
      if (e_load) chk(pc_load_val == e_lval, "R6 counter load value", pc_load_val, e_lval);
      chk(mode_we == e_mwe, "R7 mode write strobe", mode_we, e_mwe);
      if (e_mwe) chk(mode_val == e_mval, "R7 mode value", mode_val, e_mval);
    end
  end

  task automatic cyc(input logic [NC-1:0] irq, input logic done, input logic [AWB-1:0] pc,
                     input logic md, input logic r, input logic vv, input logic [AWB-1:0] vd);
    irq_req = irq; instr_done = done; pc_in = pc; mode_in = md;
    rti = r; vec_valid = vv; vec_data = vd;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    irq_req = '0; instr_done = 0; pc_in = '0; mode_in = 0; rti = 0; vec_valid = 0; vec_data = '0;
    repeat (3) cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    // R1 reset state
    chk(!save_valid && !vec_req && !pc_load && !mode_we, "R1 strobes in reset",
        {save_valid, vec_req, pc_load, mode_we}, 0);
    rst_n = 1'b1;
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    chk(!save_valid && !pc_load && !mode_we, "R1 strobes after reset",
        {save_valid, pc_load, mode_we}, 0);

    // R2: class 5 arrives without boundary
    cyc(8'h20, 0, 16'h0, 0, 0, 0, 16'h0);
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    chk(save_valid == 0, "R2 no entry without boundary", save_valid, 0);

    // R3: class 2 arrives with boundary, beats held class 5
    cyc(8'h04, 1, 16'h1234, 0, 0, 0, 16'h0);
    chk(save_valid == 1 && save_pc == 16'h1234, "R4 save on entry", save_pc, 16'h1234);
    chk(vec_req == 1 && vec_addr == 16'd20, "R3 lowest class vector", vec_addr, 20);
    chk(mode_we && mode_val, "R7 supervisor on entry", {mode_we, mode_val}, 3);

    // R12: data during request cycle ignored
    cyc('0, 0, 16'h0, 0, 0, 1, 16'h1111);
    chk(vec_req == 0, "R5 request single cycle", vec_req, 0);
    chk(pc_load == 0, "R12 early data ignored", pc_load, 0);
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    cyc('0, 0, 16'h0, 0, 0, 1, 16'h0400);
    chk(pc_load == 1 && pc_load_val == 16'h0400, "R6 vector load", pc_load_val, 16'h0400);

    // R8: masked inside handler, class 0 arrives
    cyc(8'h01, 1, 16'h0402, 1, 0, 0, 16'h0);
    chk(save_valid == 0, "R8 masked boundary", save_valid, 0);
    cyc('0, 1, 16'h0404, 1, 0, 1, 16'h2222);
    chk(save_valid == 0 && pc_load == 0, "R8 masked second boundary", {save_valid, pc_load}, 0);

    // R9: return
    cyc('0, 0, 16'h0406, 1, 1, 0, 16'h0);
    chk(pc_load && pc_load_val == 16'h1234, "R9 counter restored", pc_load_val, 16'h1234);
    chk(mode_we && mode_val == 0, "R9 mode restored", {mode_we, mode_val}, 2);

    // R11: kept class 0 taken right after return
    cyc('0, 1, 16'h2000, 0, 0, 0, 16'h0);
    chk(save_valid && vec_addr == 16'd16, "R11 kept request taken", vec_addr, 16);
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    cyc('0, 0, 16'h0, 0, 0, 1, 16'h0500);
    chk(pc_load && pc_load_val == 16'h0500, "R6 second vector load", pc_load_val, 16'h0500);
    cyc('0, 0, 16'h0, 1, 1, 0, 16'h0);
    chk(pc_load && pc_load_val == 16'h2000, "R9 second return", pc_load_val, 16'h2000);

    // R10: stray return while idle
    cyc('0, 0, 16'h0, 0, 1, 0, 16'h0);
    chk(!pc_load && !mode_we && !save_valid, "R10 idle return ignored",
        {pc_load, mode_we, save_valid}, 0);

    // R11 and R3: class 5 still pending since the start
    cyc('0, 1, 16'h3000, 1, 0, 0, 16'h0);
    chk(save_valid && vec_addr == 16'd26, "R11 class 5 taken", vec_addr, 26);
    cyc('0, 0, 16'h0, 0, 0, 0, 16'h0);
    cyc('0, 0, 16'h0, 0, 0, 1, 16'h0600);
    cyc('0, 0, 16'h0, 1, 1, 0, 16'h0);
    chk(mode_we && mode_val == 1, "R9 supervisor mode restored", {mode_we, mode_val}, 3);

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 6 == 0) ? NC'($urandom) : '0, ($urandom % 3 == 0),
          AWB'($urandom), 1'($urandom), ($urandom % 5 == 0), ($urandom % 4 == 0),
          AWB'($urandom));
    end
    summary();
  end
endmodule